// File: doc/BRIEF.md
# Integer Execute and Decode Unit

This unit decodes one 32-bit instruction word and executes the integer part of it in one clock cycle. It pulls out the two source register indices at once, so a register file outside the unit can return the two operand values, `src_a_i` and `src_b_i`. In the same cycle the unit picks the instruction format from the top bit and builds the second operand. That operand is either the second register value or a 16-bit immediate, extended the way the opcode needs. The unit then computes an arithmetic, logical, compare, shift, multiply, divide or sign-extend result.

The result, the destination index and the write-enable are registered, and they appear on the clock edge after `issue_i` is sampled high. An unsigned divide or remainder with a zero divisor raises a one-cycle fault flag and writes nothing. An opcode outside the supported set raises an illegal flag and writes nothing. Loads, stores, branches and control registers belong to other units.

Top module: `exec_unit`

## Requirements
- R1: The opcode is `instr_i[31:26]`. Bit 31 set selects register-register form and bit 31 clear selects register-immediate form. `src_a_idx_o` is `instr_i[25:21]` and `src_b_idx_o` is `instr_i[20:16]`, both combinational. The destination is `instr_i[15:11]` in register form and `instr_i[20:16]` in immediate form. The 16-bit immediate is `instr_i[15:0]`.
- R2: Add (0x0D/0x2D) and multiply (0x02/0x22) use a 16-bit immediate that is sign-extended. Multiply keeps the low 32 bits of the product.
- R3: AND 0x08/0x28, OR 0x0E/0x2E, XOR 0x06/0x26, NOR 0x01/0x21 and XNOR 0x09/0x29 zero-extend their immediate. Immediate XNOR gives the inverse of source XOR the zero-extended immediate.
- R4: Opcode 0x18 returns the source ANDed with `imm<<16`. Opcode 0x1E returns the source ORed with `imm<<16`.
- R5: Compares write 1 when the condition holds and 0 when it does not. The conditions are: equal 0x19/0x39, signed greater 0x1A/0x3A, signed greater-or-equal 0x1B/0x3B, unsigned greater-or-equal 0x1C/0x3C, unsigned greater 0x1D/0x3D, and not-equal 0x1F/0x3F. The immediate is sign-extended.
- R6: The shift opcodes are logical right 0x00/0x20, arithmetic right 0x05/0x25 and left 0x0F/0x2F. The shift amount is the low 5 bits of the second operand, which is `instr_i[4:0]` in immediate form.
- R7: Unsigned divide (0x23) and unsigned remainder (0x31) write the quotient or the remainder. A zero divisor sets `div_zero_o` and leaves `wr_en_o` low.
- R8: An instruction whose destination index is 0 never asserts `wr_en_o`.
- R9: Every opcode not listed in R2 to R7 and R10 sets `illegal_o` and leaves `wr_en_o` low.
- R10: Subtract (0x32) computes a minus b. Byte sign-extend (0x2C) and halfword sign-extend (0x37) extend the low 8 or 16 bits of source a. All three exist in register form only.
- R11: The outputs change on the clock edge after `issue_i` is sampled high. A cycle without issue gives `wr_en_o`, `div_zero_o` and `illegal_o` all low on the next edge.
- R12: While reset is held, `wr_en_o`, `div_zero_o`, `illegal_o`, `wr_idx_o` and `wr_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Instruction valid this cycle |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | XLEN | Value of the first source register |
| src_b_i | input | XLEN | Value of the second source register |
| src_a_idx_o | output | 5 | First source register index |
| src_b_idx_o | output | 5 | Second source register index |
| wr_en_o | output | 1 | Register write enable |
| wr_idx_o | output | 5 | Destination register index |
| wr_data_o | output | XLEN | Result |
| div_zero_o | output | 1 | Divide-by-zero fault |
| illegal_o | output | 1 | Unsupported opcode |

## Verification
All 64 opcodes are issued in both formats, each with six operand and immediate pairs. The pairs include operands whose top bit is set, immediates with bit 15 set, an all-ones operand and a zero divisor. These patterns separate sign extension from zero extension and signed compares from unsigned ones. They also separate arithmetic right shifts from logical ones and show that only the low five bits of the shift amount are used. Separate runs use destination 0, a zero divisor with destination 0, and idle cycles, to show that a write is held back without the other flags being disturbed.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int unsigned IDX_W = 5;
  localparam int unsigned IMM_W = 16;

  typedef enum logic [4:0] {
    ALU_ADD, ALU_SUB, ALU_MUL, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_XNOR,
    ALU_SLL, ALU_SRL, ALU_SRA, ALU_CEQ, ALU_CNE, ALU_CGT, ALU_CGE, ALU_CGTU,
    ALU_CGEU, ALU_DIVU, ALU_REMU, ALU_SEXB, ALU_SEXH
  } alu_op_e;

  typedef enum logic [1:0] {IMM_SX, IMM_ZX, IMM_HI} imm_sel_e;
endpackage

// File: rtl/exec_decode.sv
module exec_decode
  import exec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [31:0]      instr_i,
  input  logic [XLEN-1:0]  src_b_i,
  output logic [IDX_W-1:0] ra_idx_o,
  output logic [IDX_W-1:0] rb_idx_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output alu_op_e          op_o,
  output logic [XLEN-1:0]  opnd_b_o,
  output logic             legal_o
);
  logic             rr_fmt;
  logic [4:0]       opc_lo;
  logic [IMM_W-1:0] imm;
  imm_sel_e         isel;

  assign rr_fmt   = instr_i[31];
  assign opc_lo   = instr_i[30:26];
  assign imm      = instr_i[15:0];
  assign ra_idx_o = instr_i[25:21];
  assign rb_idx_o = instr_i[20:16];
  assign rd_idx_o = rr_fmt ? instr_i[15:11] : instr_i[20:16];

  always_comb begin
    op_o    = ALU_ADD;
    isel    = IMM_SX;
    legal_o = 1'b1;
    case (opc_lo)
      5'h00: begin op_o = ALU_SRL;  isel = IMM_ZX; end
      5'h01: begin op_o = ALU_NOR;  isel = IMM_ZX; end
      5'h02:       op_o = ALU_MUL;
      5'h03: begin op_o = ALU_DIVU; legal_o = rr_fmt; end
      5'h05: begin op_o = ALU_SRA;  isel = IMM_ZX; end
      5'h06: begin op_o = ALU_XOR;  isel = IMM_ZX; end
      5'h08: begin op_o = ALU_AND;  isel = IMM_ZX; end
      5'h09: begin op_o = ALU_XNOR; isel = IMM_ZX; end
      5'h0C: begin op_o = ALU_SEXB; legal_o = rr_fmt; end
      5'h0D:       op_o = ALU_ADD;
      5'h0E: begin op_o = ALU_OR;   isel = IMM_ZX; end
      5'h0F: begin op_o = ALU_SLL;  isel = IMM_ZX; end
      5'h11: begin op_o = ALU_REMU; legal_o = rr_fmt; end
      5'h12: begin op_o = ALU_SUB;  legal_o = rr_fmt; end
      5'h17: begin op_o = ALU_SEXH; legal_o = rr_fmt; end
      5'h18: begin op_o = ALU_AND;  isel = IMM_HI; legal_o = !rr_fmt; end
      5'h19:       op_o = ALU_CEQ;
      5'h1A:       op_o = ALU_CGT;
      5'h1B:       op_o = ALU_CGE;
      5'h1C:       op_o = ALU_CGEU;
      5'h1D:       op_o = ALU_CGTU;
      5'h1E: begin op_o = ALU_OR;   isel = IMM_HI; legal_o = !rr_fmt; end
      5'h1F:       op_o = ALU_CNE;
      default:     legal_o = 1'b0;
    endcase
  end

  always_comb begin
    if (rr_fmt) opnd_b_o = src_b_i;
    else begin
      case (isel)
        IMM_ZX:  opnd_b_o = {{(XLEN-IMM_W){1'b0}}, imm};
        IMM_HI:  opnd_b_o = {{(XLEN-IMM_W){1'b0}}, imm} << IMM_W;
        default: opnd_b_o = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
      endcase
    end
  end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o,
  output logic            div_zero_o
);
  localparam int unsigned SHW = $clog2(XLEN);

  logic [SHW-1:0]  shamt;
  logic            b_zero;
  logic [XLEN-1:0] quot, rem;

  assign shamt  = b_i[SHW-1:0];
  assign b_zero = (b_i == '0);
  assign quot   = b_zero ? '0 : a_i / b_i;
  assign rem    = b_zero ? '0 : a_i % b_i;

  function automatic logic [XLEN-1:0] flag(input logic c);
    return {{(XLEN-1){1'b0}}, c};
  endfunction

  always_comb begin
    div_zero_o = 1'b0;
    case (op_i)
      ALU_ADD:  res_o = a_i + b_i;
      ALU_SUB:  res_o = a_i - b_i;
      ALU_MUL:  res_o = a_i * b_i;
      ALU_AND:  res_o = a_i & b_i;
      ALU_OR:   res_o = a_i | b_i;
      ALU_XOR:  res_o = a_i ^ b_i;
      ALU_NOR:  res_o = ~(a_i | b_i);
      ALU_XNOR: res_o = ~(a_i ^ b_i);
      ALU_SLL:  res_o = a_i << shamt;
      ALU_SRL:  res_o = a_i >> shamt;
      ALU_SRA:  res_o = $unsigned($signed(a_i) >>> shamt);
      ALU_CEQ:  res_o = flag(a_i == b_i);
      ALU_CNE:  res_o = flag(a_i != b_i);
      ALU_CGT:  res_o = flag($signed(a_i) > $signed(b_i));
      ALU_CGE:  res_o = flag($signed(a_i) >= $signed(b_i));
      ALU_CGTU: res_o = flag(a_i > b_i);
      ALU_CGEU: res_o = flag(a_i >= b_i);
      ALU_DIVU: begin res_o = quot; div_zero_o = b_zero; end
      ALU_REMU: begin res_o = rem;  div_zero_o = b_zero; end
      ALU_SEXB: res_o = {{(XLEN-8){a_i[7]}}, a_i[7:0]};
      ALU_SEXH: res_o = {{(XLEN-16){a_i[15]}}, a_i[15:0]};
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [31:0]      instr_i,
  input  logic [XLEN-1:0]  src_a_i,
  input  logic [XLEN-1:0]  src_b_i,
  output logic [IDX_W-1:0] src_a_idx_o,
  output logic [IDX_W-1:0] src_b_idx_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [XLEN-1:0]  wr_data_o,
  output logic             div_zero_o,
  output logic             illegal_o
);
  logic [IDX_W-1:0] rd_idx;
  alu_op_e          op;
  logic [XLEN-1:0]  opnd_b, res;
  logic             legal, dz;

  exec_decode #(.XLEN(XLEN)) u_dec (
    .instr_i  (instr_i),
    .src_b_i  (src_b_i),
    .ra_idx_o (src_a_idx_o),
    .rb_idx_o (src_b_idx_o),
    .rd_idx_o (rd_idx),
    .op_o     (op),
    .opnd_b_o (opnd_b),
    .legal_o  (legal)
  );

  exec_alu #(.XLEN(XLEN)) u_alu (
    .op_i       (op),
    .a_i        (src_a_i),
    .b_i        (opnd_b),
    .res_o      (res),
    .div_zero_o (dz)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o    <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
      div_zero_o <= 1'b0;
      illegal_o  <= 1'b0;
    end else begin
      wr_en_o    <= issue_i && legal && !dz && (rd_idx != '0);
      div_zero_o <= issue_i && legal && dz;
      illegal_o  <= issue_i && !legal;
      if (issue_i) begin
        wr_idx_o  <= rd_idx;
        wr_data_o <= res;
      end
    end
  end

  p_fault_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_zero_o |-> !wr_en_o);
  p_illegal_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wr_en_o && !div_zero_o);
  p_no_zero_dest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_idx_o != '0);
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> !wr_en_o && !div_zero_o && !illegal_o);
  p_cmp_bool_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && (instr_i[30:26] inside {[5'h19:5'h1D], 5'h1F}) |=>
      wr_data_o[XLEN-1:1] == '0);
endmodule

// File: tb/exec_unit_tb.sv
module exec_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic [4:0]  src_a_idx_o, src_b_idx_o, wr_idx_o;
  logic        wr_en_o, div_zero_o, illegal_o;
  logic [31:0] wr_data_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  exec_unit #(.XLEN(32)) u_dut (.*);

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 200000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [5:0] op);
    case (op)
      6'h0D, 6'h2D, 6'h02, 6'h22: return "R2";
      6'h08, 6'h28, 6'h0E, 6'h2E, 6'h06, 6'h26, 6'h01, 6'h21, 6'h09, 6'h29: return "R3";
      6'h18, 6'h1E: return "R4";
      6'h19, 6'h1A, 6'h1B, 6'h1C, 6'h1D, 6'h1F,
      6'h39, 6'h3A, 6'h3B, 6'h3C, 6'h3D, 6'h3F: return "R5";
      6'h00, 6'h20, 6'h05, 6'h25, 6'h0F, 6'h2F: return "R6";
      6'h23, 6'h31: return "R7";
      6'h32, 6'h2C, 6'h37: return "R10";
      default: return "R9";
    endcase
  endfunction

  // Reference model: legal, fault, data
  task automatic model(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] imm, output logic ok, output logic dz,
                       output logic [31:0] d);
    logic [31:0] sx, zx, hi;
    sx = {{16{imm[15]}}, imm};
    zx = {16'h0, imm};
    hi = {imm, 16'h0};
    ok = 1'b1; dz = 1'b0; d = '0;
    case (op)
      6'h00: d = a >> zx[4:0];
      6'h20: d = a >> b[4:0];
      6'h05: d = $unsigned($signed(a) >>> zx[4:0]);
      6'h25: d = $unsigned($signed(a) >>> b[4:0]);
      6'h0F: d = a << zx[4:0];
      6'h2F: d = a << b[4:0];
      6'h01: d = ~(a | zx);
      6'h21: d = ~(a | b);
      6'h06: d = a ^ zx;
      6'h26: d = a ^ b;
      6'h08: d = a & zx;
      6'h28: d = a & b;
      6'h09: d = ~(a ^ zx);
      6'h29: d = ~(a ^ b);
      6'h0E: d = a | zx;
      6'h2E: d = a | b;
      6'h0D: d = a + sx;
      6'h2D: d = a + b;
      6'h02: d = a * sx;
      6'h22: d = a * b;
      6'h18: d = a & hi;
      6'h1E: d = a | hi;
      6'h19: d = 32'(a == sx);
      6'h39: d = 32'(a == b);
      6'h1A: d = 32'($signed(a) > $signed(sx));
      6'h3A: d = 32'($signed(a) > $signed(b));
      6'h1B: d = 32'($signed(a) >= $signed(sx));
      6'h3B: d = 32'($signed(a) >= $signed(b));
      6'h1C: d = 32'(a >= sx);
      6'h3C: d = 32'(a >= b);
      6'h1D: d = 32'(a > sx);
      6'h3D: d = 32'(a > b);
      6'h1F: d = 32'(a != sx);
      6'h3F: d = 32'(a != b);
      6'h23: if (b == 0) dz = 1'b1; else d = a / b;
      6'h31: if (b == 0) dz = 1'b1; else d = a % b;
      6'h32: d = a - b;
      6'h2C: d = {{24{a[7]}}, a[7:0]};
      6'h37: d = {{16{a[15]}}, a[15:0]};
      default: ok = 1'b0;
    endcase
  endtask

  task automatic run(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    logic ok, dz;
    logic [31:0] d;
    logic [4:0] rd;
    logic [5:0] op;
    string t;
    op = ins[31:26];
    t = tag_of(op);
    rd = ins[31] ? ins[15:11] : ins[20:16];
    model(op, a, b, ins[15:0], ok, dz, d);
    @(negedge clk_i);
    instr_i = ins; src_a_i = a; src_b_i = b; issue_i = 1'b1;
    #1;
    // R1: source index fields
    chk("R1", "src_a_idx", 32'(src_a_idx_o), 32'(ins[25:21]));
    chk("R1", "src_b_idx", 32'(src_b_idx_o), 32'(ins[20:16]));
    @(negedge clk_i);
    issue_i = 1'b0;
    chk(t, "wr_en", 32'(wr_en_o), 32'(ok && !dz && rd != 0));
    chk(t, "illegal", 32'(illegal_o), 32'(!ok));
    chk(t, "div_zero", 32'(div_zero_o), 32'(ok && dz));
    if (ok && !dz) begin
      chk(t, "wr_data", wr_data_o, d);
      chk("R1", "wr_idx", 32'(wr_idx_o), 32'(rd));
    end
  endtask

  logic [31:0] pa [6] = '{32'h0000_0005, 32'hFFFF_FFF0, 32'h8000_0000,
                          32'h1234_5678, 32'h7FFF_FFFF, 32'hDEAD_BEEF};
  logic [31:0] pb [6] = '{32'h0000_0003, 32'h0000_0010, 32'hFFFF_FFFF,
                          32'h0000_0000, 32'h8000_0000, 32'h0000_0025};
  logic [15:0] pi [6] = '{16'h0003, 16'hFFF0, 16'h8000, 16'h0000, 16'h7FFF, 16'h00A5};

  initial begin
    #5;
    // R12: reset state
    chk("R12", "wr_en", 32'(wr_en_o), 0);
    chk("R12", "div_zero", 32'(div_zero_o), 0);
    chk("R12", "illegal", 32'(illegal_o), 0);
    chk("R12", "wr_idx", 32'(wr_idx_o), 0);
    chk("R12", "wr_data", wr_data_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int op = 0; op < 64; op++) begin
      for (int p = 0; p < 6; p++) begin
        logic [4:0] ra, rb, rd;
        logic [31:0] ins;
        ra = 5'(op + p + 1);
        rb = 5'(p * 5 + 2);
        rd = 5'((op + 3 * p) % 31 + 1);
        if (op >= 32) ins = {6'(op), ra, rb, rd, 11'h2A5};
        else          ins = {6'(op), ra, rd, pi[p]};
        run(ins, pa[p], pb[p]);
      end
    end

    // R8: destination 0 suppressed, immediate and register forms
    run({6'h0D, 5'd3, 5'd0, 16'h0001}, 32'h10, 32'h0);
    run({6'h2D, 5'd3, 5'd4, 5'd0, 11'h0}, 32'h10, 32'h20);
    // R7: zero divisor with destination 0 still faults
    run({6'h23, 5'd3, 5'd4, 5'd0, 11'h0}, 32'h10, 32'h0);
    // R7: quotient and remainder
    run({6'h23, 5'd3, 5'd4, 5'd9, 11'h0}, 32'd100, 32'd7);
    run({6'h31, 5'd3, 5'd4, 5'd9, 11'h0}, 32'd100, 32'd7);
    // R6: shift amount taken from low 5 bits only
    run({6'h2F, 5'd1, 5'd2, 5'd3, 11'h0}, 32'h0000_0001, 32'hFFFF_FFE4);

    // R11: no issue means no write and no flags
    @(negedge clk_i);
    instr_i = {6'h2D, 5'd1, 5'd2, 5'd3, 11'h0};
    issue_i = 1'b0;
    @(negedge clk_i);
    chk("R11", "idle wr_en", 32'(wr_en_o), 0);
    chk("R11", "idle illegal", 32'(illegal_o), 0);
    chk("R11", "idle div_zero", 32'(div_zero_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule